// File: doc/BRIEF.md
# Block Cipher Register Front-End

This block is the software-visible face of a 64-bit-block cipher engine. A host reads and writes 32-bit words over a plain register port. Through that port it loads key words, a two-word chaining vector and mode flags, and it pushes each plaintext or ciphertext block as two data words. On the other side, a valid/ready port hands each complete block to the cipher core together with the key, the vector and the mode, and another valid/ready port takes the core's result back.

The host paces the transfer one block at a time. It writes both input words while the input buffer can accept them. The buffer then presents the block to the core. When the core returns a result, the block holds it until the host has read both output words. Two pending causes mark that the input buffer has emptied and that a result is waiting. Each cause can be enabled onto a single interrupt line. Software normally enables the two causes alternately, so the input side and the output side take turns driving the transfer.

The key words sit at pair-swapped addresses below the chaining vector. The address of key word n is 0x14 − ((n XOR 1) × 4). Words 0 to 5 therefore appear at 0x10, 0x14, 0x08, 0x0C, 0x00 and 0x04.

Top module: `blk_cipher_csr`

## Requirements
- R1: After reset the control word reads 0x02, the status word reads 0x02, the enable word reads 0, every key, vector and data word reads 0, the interrupt is low, no block is offered to the core and a result is accepted from it.
- R2: Key word n (n = 0..5) is read/write at byte address 0x14 − ((n XOR 1) × 4) and drives core_key bits [32n+31:32n].
- R3: The chaining vector words at 0x18 and 0x1C are read/write and drive core_iv bits 31:0 and 63:32 respectively.
- R4: The control word at 0x20 has chained mode in bit 4, triple mode in bit 3 and encrypt direction in bit 2, all read/write and driving core_chain, core_triple and core_encrypt. Bit 1 (input can accept a block) and bit 0 (result waiting) are read-only, and writes to them are ignored.
- R5: A write to 0x28 loads input bits 31:0 and a write to 0x2C loads bits 63:32. Once both words are loaded, core_in_valid rises in the next cycle with that block and control bit 1 reads 0. Bit 1 reads 1 otherwise. A cycle with core_in_valid and core_in_ready high empties the buffer.
- R6: While a loaded block waits for the core, writes to 0x28 and 0x2C are ignored and the offered block stays unchanged.
- R7: core_out_ready is high while no result is held. An accepted result reads back as bits 31:0 at 0x28 and bits 63:32 at 0x2C, and control bit 0 reads 1. The result is released only once both words have been read, in either order. Results offered while one is held are not taken.
- R8: Status bit 1 (input emptied) and bit 2 (result waiting) are set at the edge after the input block is taken and after a result is accepted. Bit 1 is also set by reset. Bit 1 clears when the input buffer fills, and bit 2 clears when the result is released. Writing 0x3C with a cause bit at 0 clears that cause, and writing it with a 1 has no effect. A set event in the same cycle as a clearing write wins.
- R9: The enable word at 0x40 holds enables in bits 1 and 2, and irq is high exactly when some status bit and its enable are both 1.
- R10: The word at 0x30 reads the major revision (default 2) in bits 10:8 and the minor revision (default 5) in bits 5:0. All other bits read 0.
- R11: Addresses outside the map read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on data window) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_key | output | 192 | Key words, word n in bits 32n+31:32n |
| core_iv | output | 64 | Chaining vector |
| core_chain | output | 1 | Chained mode select |
| core_triple | output | 1 | Triple mode select |
| core_encrypt | output | 1 | 1 = encrypt, 0 = decrypt |
| core_in_valid | output | 1 | Input block offered to core |
| core_in_ready | input | 1 | Core takes the input block |
| core_in_block | output | 64 | Input block |
| core_out_valid | input | 1 | Core offers a result |
| core_out_ready | output | 1 | Result holding register is free |
| core_out_block | input | 64 | Result block |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cycle where a write completes the input block, because a design that counts writes instead of tracking each word would offer a half-written block after two writes to the same address. It reads the result words in both orders and repeats one word. A design that released on the high word alone would drop the result early and let a second result overwrite it. It hits a clearing status write in the same cycle as a capture, where a wrong priority loses an interrupt. It also writes the read-only control bits and the data window while the buffer is full, which a careless decode would let corrupt the ready flags or the block in flight.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
   // Register map (byte offsets)
   localparam int OFS_KEY_TOP = 'h14;  // key word n at OFS_KEY_TOP - ((n^1)*4)
   localparam int OFS_VEC     = 'h18;
   localparam int OFS_CTRL    = 'h20;
   localparam int OFS_DATA    = 'h28;
   localparam int OFS_REV     = 'h30;
   localparam int OFS_STAT    = 'h3C;
   localparam int OFS_IEN     = 'h40;

   // Control bit positions
   localparam int CB_CHAIN  = 4;
   localparam int CB_TRIPLE = 3;
   localparam int CB_ENC    = 2;
   localparam int CB_INRDY  = 1;
   localparam int CB_OUTRDY = 0;

   // Interrupt cause positions: data-in at CAUSE_LSB, data-out at CAUSE_LSB+1
   localparam int CAUSE_LSB = 1;
   localparam int N_CAUSE   = 2;

   typedef struct packed {
      logic chain;
      logic triple;
      logic encrypt;
   } cfr_mode_t;

   function automatic int key_word_ofs(int n);
      return OFS_KEY_TOP - ((n ^ 1) * 4);
   endfunction
endpackage

// File: rtl/cfr_key_bank.sv
module cfr_key_bank #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int KEY_WORDS = 6,
   parameter int VEC_WORDS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   output logic [KEY_WORDS*DATA_W-1:0]   key_flat,
   output logic [VEC_WORDS*DATA_W-1:0]   vec_flat,
   output logic                          rd_hit,
   output logic [DATA_W-1:0]             rd_val
);
   import cfr_pkg::*;

   localparam int N_REG = KEY_WORDS + VEC_WORDS;

   logic [DATA_W-1:0] word_q [N_REG];
   logic [N_REG-1:0]  sel;

   for (genvar i = 0; i < N_REG; i++) begin : g_word
      localparam int WOFS = (i < KEY_WORDS) ? key_word_ofs(i)
                                            : OFS_VEC + 4 * (i - KEY_WORDS);
      assign sel[i] = (addr == ADDR_W'(WOFS));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[i] <= '0;
         else if (wr_en && sel[i])
            word_q[i] <= wdata;
      end

      if (i < KEY_WORDS) begin : g_key
         assign key_flat[i*DATA_W +: DATA_W] = word_q[i];
      end else begin : g_vec
         assign vec_flat[(i-KEY_WORDS)*DATA_W +: DATA_W] = word_q[i];
      end
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < N_REG; i++)
         if (sel[i]) rd_val = word_q[i];
   end
   assign rd_hit = |sel;
endmodule

// File: rtl/cfr_in_buffer.sv
module cfr_in_buffer #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [WORDS-1:0]          wr_sel,
   input  logic [DATA_W-1:0]         wdata,
   input  logic                      take_ready,
   output logic                      blk_valid,
   output logic [WORDS*DATA_W-1:0]   blk,
   output logic                      can_accept,
   output logic                      fill_evt,
   output logic                      take_evt
);
   logic [WORDS-1:0] loaded_q;
   logic             full;

   assign full       = &loaded_q;
   assign can_accept = ~full;
   assign take_evt   = full & take_ready;
   // buffer completes this cycle: every word either held or being written
   assign fill_evt   = ~full & (&(loaded_q | wr_sel));
   assign blk_valid  = full;

   for (genvar w = 0; w < WORDS; w++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            loaded_q[w]               <= 1'b0;
            blk[w*DATA_W +: DATA_W]   <= '0;
         end else if (take_evt) begin
            loaded_q[w]               <= 1'b0;
         end else if (~full && wr_sel[w]) begin
            loaded_q[w]               <= 1'b1;
            blk[w*DATA_W +: DATA_W]   <= wdata;
         end
      end
   end
endmodule

// File: rtl/cfr_out_buffer.sv
module cfr_out_buffer #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [WORDS-1:0]          rd_sel,
   input  logic                      res_valid,
   input  logic [WORDS*DATA_W-1:0]   res_blk,
   output logic                      res_ready,
   output logic [WORDS*DATA_W-1:0]   held,
   output logic                      holding,
   output logic                      cap_evt,
   output logic                      drain_evt
);
   logic [WORDS-1:0] seen_q;
   logic [WORDS-1:0] hit;

   assign res_ready = ~holding;
   assign cap_evt   = res_valid & ~holding;
   assign hit       = rd_sel & {WORDS{holding}};
   assign drain_evt = holding & (&(seen_q | hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         holding <= 1'b0;
         held    <= '0;
      end else if (cap_evt) begin
         holding <= 1'b1;
         held    <= res_blk;
      end else if (drain_evt) begin
         holding <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= '0;
      else if (drain_evt)
         seen_q <= '0;
      else
         seen_q <= seen_q | hit;
   end
endmodule

// File: rtl/cfr_irq_unit.sv
module cfr_irq_unit #(
   parameter int                 N_CAUSE  = 2,
   parameter logic [N_CAUSE-1:0] RST_PEND = 'b01
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stat_wr,
   input  logic               en_wr,
   input  logic [N_CAUSE-1:0] wbits,
   input  logic [N_CAUSE-1:0] hw_set,
   input  logic [N_CAUSE-1:0] hw_clr,
   output logic [N_CAUSE-1:0] pend,
   output logic [N_CAUSE-1:0] en,
   output logic               irq
);
   for (genvar c = 0; c < N_CAUSE; c++) begin : g_cause
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend[c] <= RST_PEND[c];
         else if (hw_set[c])
            pend[c] <= 1'b1;
         else if (hw_clr[c] || (stat_wr && !wbits[c]))
            pend[c] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en[c] <= 1'b0;
         else if (en_wr)
            en[c] <= wbits[c];
      end
   end

   assign irq = |(pend & en);
endmodule

// File: rtl/blk_cipher_csr.sv
module blk_cipher_csr #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int BLK_W     = 64,
   parameter int KEY_WORDS = 6,
   parameter int REV_MAJOR = 2,
   parameter int REV_MINOR = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic                        bus_rd,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic [KEY_WORDS*DATA_W-1:0] core_key,
   output logic [BLK_W-1:0]            core_iv,
   output logic                        core_chain,
   output logic                        core_triple,
   output logic                        core_encrypt,
   output logic                        core_in_valid,
   input  logic                        core_in_ready,
   output logic [BLK_W-1:0]            core_in_block,
   input  logic                        core_out_valid,
   output logic                        core_out_ready,
   input  logic [BLK_W-1:0]            core_out_block,
   output logic                        irq
);
   import cfr_pkg::*;

   localparam int N_DW = BLK_W / DATA_W;

   // Elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_dw
      $error("blk_cipher_csr: DATA_W must be 32");
   end
   if (BLK_W != 2 * DATA_W) begin : g_bad_blk
      $error("blk_cipher_csr: BLK_W must be two data words");
   end
   if (KEY_WORDS < 2 || KEY_WORDS > 6 || (KEY_WORDS % 2) != 0) begin : g_bad_key
      $error("blk_cipher_csr: KEY_WORDS must be 2, 4 or 6");
   end
   if (ADDR_W < 7) begin : g_bad_aw
      $error("blk_cipher_csr: ADDR_W too small for register map");
   end
   if (REV_MAJOR < 0 || REV_MAJOR > 7 || REV_MINOR < 0 || REV_MINOR > 63) begin : g_bad_rev
      $error("blk_cipher_csr: revision field out of range");
   end

   // Address decode
   logic hit_ctrl, hit_rev, hit_stat, hit_ien;
   logic [N_DW-1:0] hit_data;

   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_rev  = (bus_addr == ADDR_W'(OFS_REV));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_ien  = (bus_addr == ADDR_W'(OFS_IEN));

   for (genvar w = 0; w < N_DW; w++) begin : g_data_dec
      assign hit_data[w] = (bus_addr == ADDR_W'(OFS_DATA + 4 * w));
   end

   // Key and chaining-vector storage
   logic              kb_hit;
   logic [DATA_W-1:0] kb_val;

   cfr_key_bank #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .KEY_WORDS (KEY_WORDS),
      .VEC_WORDS (N_DW)
   ) u_keys (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .key_flat (core_key),
      .vec_flat (core_iv),
      .rd_hit   (kb_hit),
      .rd_val   (kb_val)
   );

   // Mode flags
   cfr_mode_t mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= '0;
      else if (bus_wr && hit_ctrl) begin
         mode_q.chain   <= bus_wdata[CB_CHAIN];
         mode_q.triple  <= bus_wdata[CB_TRIPLE];
         mode_q.encrypt <= bus_wdata[CB_ENC];
      end
   end

   assign core_chain   = mode_q.chain;
   assign core_triple  = mode_q.triple;
   assign core_encrypt = mode_q.encrypt;

   // Input side
   logic in_accept, in_fill, in_take;

   cfr_in_buffer #(
      .DATA_W (DATA_W),
      .WORDS  (N_DW)
   ) u_inbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_sel     (hit_data & {N_DW{bus_wr}}),
      .wdata      (bus_wdata),
      .take_ready (core_in_ready),
      .blk_valid  (core_in_valid),
      .blk        (core_in_block),
      .can_accept (in_accept),
      .fill_evt   (in_fill),
      .take_evt   (in_take)
   );

   // Output side
   logic [BLK_W-1:0] out_held;
   logic             out_full, out_cap, out_drain;

   cfr_out_buffer #(
      .DATA_W (DATA_W),
      .WORDS  (N_DW)
   ) u_outbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_sel    (hit_data & {N_DW{bus_rd}}),
      .res_valid (core_out_valid),
      .res_blk   (core_out_block),
      .res_ready (core_out_ready),
      .held      (out_held),
      .holding   (out_full),
      .cap_evt   (out_cap),
      .drain_evt (out_drain)
   );

   // Interrupt causes: index 0 = data-in, index 1 = data-out
   logic [N_CAUSE-1:0] pend_bits, en_bits;

   cfr_irq_unit #(
      .N_CAUSE  (N_CAUSE),
      .RST_PEND (N_CAUSE'(1))
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_wr (bus_wr && hit_stat),
      .en_wr   (bus_wr && hit_ien),
      .wbits   (bus_wdata[CAUSE_LSB +: N_CAUSE]),
      .hw_set  ({out_cap, in_take}),
      .hw_clr  ({out_drain, in_fill}),
      .pend    (pend_bits),
      .en      (en_bits),
      .irq     (irq)
   );

   // Read words
   logic [DATA_W-1:0] ctrl_word, rev_word, stat_word, ien_word;

   always_comb begin
      ctrl_word            = '0;
      ctrl_word[CB_CHAIN]  = mode_q.chain;
      ctrl_word[CB_TRIPLE] = mode_q.triple;
      ctrl_word[CB_ENC]    = mode_q.encrypt;
      ctrl_word[CB_INRDY]  = in_accept;
      ctrl_word[CB_OUTRDY] = out_full;

      rev_word             = '0;
      rev_word[10:8]       = 3'(REV_MAJOR);
      rev_word[5:0]        = 6'(REV_MINOR);

      stat_word                        = '0;
      stat_word[CAUSE_LSB +: N_CAUSE]  = pend_bits;
      ien_word                         = '0;
      ien_word[CAUSE_LSB +: N_CAUSE]   = en_bits;
   end

   always_comb begin
      bus_rdata = '0;
      if (kb_hit)        bus_rdata = kb_val;
      else if (hit_ctrl) bus_rdata = ctrl_word;
      else if (hit_rev)  bus_rdata = rev_word;
      else if (hit_stat) bus_rdata = stat_word;
      else if (hit_ien)  bus_rdata = ien_word;
      for (int w = 0; w < N_DW; w++)
         if (hit_data[w]) bus_rdata = out_held[w*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
   parameter int BLK_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             core_in_valid,
   input logic             core_in_ready,
   input logic [BLK_W-1:0] core_in_block,
   input logic             core_out_valid,
   input logic             core_out_ready,
   input logic             irq,
   input logic [1:0]       pend_bits,
   input logic [1:0]       en_bits
);
   AST_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      core_in_valid && core_in_ready |=> !core_in_valid); // R5

   AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      core_in_valid && !core_in_ready |=> core_in_valid && $stable(core_in_block)); // R6

   AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      core_out_valid && core_out_ready |=> !core_out_ready); // R7

   AST_DIN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      core_in_valid && core_in_ready |=> pend_bits[0]); // R8

   AST_DOUT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      core_out_valid && core_out_ready |=> pend_bits[1]); // R8

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_bits == 2'b00) |-> !irq); // R9
endmodule

bind blk_cipher_csr cfr_checker #(.BLK_W(BLK_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .core_in_valid  (core_in_valid),
   .core_in_ready  (core_in_ready),
   .core_in_block  (core_in_block),
   .core_out_valid (core_out_valid),
   .core_out_ready (core_out_ready),
   .irq            (irq),
   .pend_bits      (pend_bits),
   .en_bits        (en_bits)
);

// File: tb/blk_cipher_csr_tb.sv
`timescale 1ns/10ps
module blk_cipher_csr_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [191:0] core_key;
   logic [63:0]  core_iv, core_in_block;
   logic [63:0]  core_out_block = '0;
   logic         core_chain, core_triple, core_encrypt;
   logic         core_in_valid, core_out_ready, irq;
   logic         core_in_ready = 1'b0, core_out_valid = 1'b0;

   int  vectors = 0, miscompares = 0;
   bit  done = 0;

   always #5 clk = ~clk;

   blk_cipher_csr u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_key(core_key), .core_iv(core_iv), .core_chain(core_chain),
      .core_triple(core_triple), .core_encrypt(core_encrypt),
      .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
      .core_in_block(core_in_block), .core_out_valid(core_out_valid),
      .core_out_ready(core_out_ready), .core_out_block(core_out_block),
      .irq(irq)
   );

   // ---------------- reference model ----------------
   bit [31:0] mkey [6];
   bit [31:0] miv  [2];
   bit [31:0] mdin [2];
   bit [31:0] mdout[2];
   bit        mf   [2];
   bit        mrd  [2];
   bit        mof, mpin, mpout, men_in, men_out;
   bit [2:0]  mmode;   // chain, triple, encrypt

   function automatic bit [7:0] kaddr(int n);
      return 8'(8'h14 - ((n ^ 1) * 4));
   endfunction

   function automatic void model_reset();
      for (int i = 0; i < 6; i++) mkey[i] = 0;
      for (int i = 0; i < 2; i++) begin
         miv[i] = 0; mdin[i] = 0; mdout[i] = 0; mf[i] = 0; mrd[i] = 0;
      end
      mof = 0; mpin = 1; mpout = 0; men_in = 0; men_out = 0; mmode = 0;
   endfunction

   function automatic bit [31:0] model_read(bit [7:0] a);
      bit [31:0] r = 0;
      for (int n = 0; n < 6; n++) if (a == kaddr(n)) r = mkey[n];
      case (a)
         8'h18: r = miv[0];
         8'h1C: r = miv[1];
         8'h20: r = {27'd0, mmode, !(mf[0] && mf[1]), mof};
         8'h28: r = mdout[0];
         8'h2C: r = mdout[1];
         8'h30: r = 32'h0000_0205;
         8'h3C: r = {29'd0, mpout, mpin, 1'b0};
         8'h40: r = {29'd0, men_out, men_in, 1'b0};
         default: ;
      endcase
      return r;
   endfunction

   function automatic void model_update();
      bit full = mf[0] && mf[1];
      bit take = full && core_in_ready;
      bit cap  = !mof && core_out_valid;
      bit fill = 0, drain = 0, h0, h1;
      if (bus_wr) begin
         for (int n = 0; n < 6; n++) if (bus_addr == kaddr(n)) mkey[n] = bus_wdata;
         if (bus_addr == 8'h18) miv[0] = bus_wdata;
         if (bus_addr == 8'h1C) miv[1] = bus_wdata;
         if (bus_addr == 8'h20) mmode = bus_wdata[4:2];
         if (bus_addr == 8'h40) {men_out, men_in} = bus_wdata[2:1];
         if (!full && bus_addr == 8'h28) begin mdin[0] = bus_wdata; mf[0] = 1; end
         if (!full && bus_addr == 8'h2C) begin mdin[1] = bus_wdata; mf[1] = 1; end
         if (!full && mf[0] && mf[1]) fill = 1;
         if (bus_addr == 8'h3C) begin
            if (!bus_wdata[1]) mpin = 0;
            if (!bus_wdata[2]) mpout = 0;
         end
      end
      h0 = bus_rd && mof && bus_addr == 8'h28;
      h1 = bus_rd && mof && bus_addr == 8'h2C;
      if (mof && (mrd[0] || h0) && (mrd[1] || h1)) begin
         drain = 1; mof = 0; mrd[0] = 0; mrd[1] = 0;
      end else begin
         mrd[0] = mrd[0] || h0; mrd[1] = mrd[1] || h1;
      end
      if (fill)  mpin = 0;
      if (drain) mpout = 0;
      if (take) begin mpin = 1; mf[0] = 0; mf[1] = 0; end
      if (cap) begin
         mof = 1; mpout = 1;
         mdout[0] = core_out_block[31:0]; mdout[1] = core_out_block[63:32];
      end
   endfunction

   task automatic cmp(string tag, string what, logic [191:0] act, logic [191:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare every output against the model, then advance one clock
   task automatic step();
      bit [191:0] ek;
      #0.1;
      for (int n = 0; n < 6; n++) ek[n*32 +: 32] = mkey[n];
      cmp("R2", "core_key", core_key, ek);
      cmp("R3", "core_iv", core_iv, {miv[1], miv[0]});
      cmp("R4", "mode", {core_chain, core_triple, core_encrypt}, mmode);
      cmp("R5", "in_valid", core_in_valid, mf[0] && mf[1]);
      if (mf[0] && mf[1]) cmp("R6", "in_block", core_in_block, {mdin[1], mdin[0]});
      cmp("R7", "out_ready", core_out_ready, !mof);
      cmp("R11", "rdata", bus_rdata, model_read(bus_addr));
      cmp("R9", "irq", irq, (mpin && men_in) || (mpout && men_out));
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic wr(bit [7:0] a, bit [31:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      step();
      bus_wr = 0;
   endtask

   task automatic rd(bit [7:0] a);
      bus_rd = 1; bus_addr = a;
      step();
      bus_rd = 0;
   endtask

   task automatic peek(bit [7:0] a, output bit [31:0] v);
      bus_addr = a;
      #0.1;
      v = bus_rdata;
   endtask

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      cmp(tag, what, {128'd0, act}, {128'd0, exp});
   endtask

   task automatic give_result(bit [63:0] b);
      core_out_valid = 1; core_out_block = b;
      step();
      core_out_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      bit [31:0] v;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      peek(8'h20, v); chk("R1", "ctrl", v, 32'h02);
      peek(8'h3C, v); chk("R1", "status", v, 32'h02);
      peek(8'h40, v); chk("R1", "enable", v, 0);
      chk("R1", "irq/in_valid/out_ready", {irq, core_in_valid, core_out_ready}, 3'b001);

      // R2: pair-swapped key addresses
      for (int n = 0; n < 6; n++) wr(kaddr(n), 32'hA0A0_0000 + n);
      peek(8'h10, v); chk("R2", "key0@0x10", v, 32'hA0A0_0000);
      peek(8'h00, v); chk("R2", "key4@0x00", v, 32'hA0A0_0004);
      chk("R2", "core_key word2", core_key[95:64], 32'hA0A0_0002);

      // R3: chaining vector
      wr(8'h18, 32'h1111_2222); wr(8'h1C, 32'h3333_4444);
      chk("R3", "core_iv", core_iv, 64'h3333_4444_1111_2222);

      // R4: mode bits, read-only ready bits
      wr(8'h20, 32'h1F);
      peek(8'h20, v); chk("R4", "ctrl all", v, 32'h1E);
      chk("R4", "mode pins", {core_chain, core_triple, core_encrypt}, 3'b111);
      wr(8'h20, 32'h08);
      peek(8'h20, v); chk("R4", "ctrl triple", v, 32'h0A);

      // R9 / R8: enable and clear
      wr(8'h40, 32'h2);
      chk("R9", "irq on din", irq, 1);
      wr(8'h3C, 32'h4);
      peek(8'h3C, v); chk("R8", "status cleared", v, 0);
      chk("R9", "irq off", irq, 0);
      wr(8'h3C, 32'h6);
      peek(8'h3C, v); chk("R8", "write ones no set", v, 0);

      // R5 / R6: input block
      wr(8'h2C, 32'hDEAD_BEEF);
      chk("R5", "half block not offered", core_in_valid, 0);
      wr(8'h2C, 32'hDEAD_BEEF);
      chk("R5", "same word twice not offered", core_in_valid, 0);
      wr(8'h28, 32'h0123_4567);
      chk("R5", "block offered", core_in_valid, 1);
      chk("R5", "block value", core_in_block, 64'hDEAD_BEEF_0123_4567);
      peek(8'h20, v); chk("R5", "ctrl full", v, 32'h08);
      wr(8'h28, 32'hFFFF_FFFF);
      chk("R6", "block kept", core_in_block, 64'hDEAD_BEEF_0123_4567);
      core_in_ready = 1; step(); core_in_ready = 0;
      chk("R5", "drained", core_in_valid, 0);
      peek(8'h3C, v); chk("R8", "din pending", v, 32'h2);
      chk("R9", "irq din", irq, 1);

      // R7: result held until both words read
      give_result(64'hCAFE_F00D_1234_5678);
      chk("R7", "out_ready low", core_out_ready, 0);
      peek(8'h20, v); chk("R7", "ctrl outrdy", v, 32'h0B);
      give_result(64'h5555_5555_5555_5555);
      peek(8'h28, v); chk("R7", "second result ignored", v, 32'h1234_5678);
      rd(8'h28);
      chk("R7", "one word read still held", core_out_ready, 0);
      rd(8'h28);
      chk("R7", "repeat word still held", core_out_ready, 0);
      rd(8'h2C);
      chk("R7", "released", core_out_ready, 1);
      peek(8'h3C, v); chk("R8", "dout cleared", v, 32'h2);

      give_result(64'h0BAD_0BAD_7777_8888);
      rd(8'h2C); rd(8'h2C);
      chk("R7", "hi only held", core_out_ready, 0);
      rd(8'h28);
      chk("R7", "reverse order released", core_out_ready, 1);

      // R8: set wins over clearing write
      bus_wr = 1; bus_addr = 8'h3C; bus_wdata = 0;
      core_out_valid = 1; core_out_block = 64'h1;
      step();
      bus_wr = 0; core_out_valid = 0;
      peek(8'h3C, v); chk("R8", "set beats clear", v, 32'h4);
      wr(8'h3C, 32'h0);
      peek(8'h20, v); chk("R8", "clear keeps result", v, 32'h0B);
      wr(8'h40, 32'h4);
      chk("R9", "dout enabled but cleared", irq, 0);
      rd(8'h28); rd(8'h2C);

      // R10, R11
      peek(8'h30, v); chk("R10", "revision", v, 32'h0000_0205);
      wr(8'h24, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
      peek(8'h24, v); chk("R11", "unmapped 0x24", v, 0);
      peek(8'h44, v); chk("R11", "unmapped 0x44", v, 0);
      peek(8'h20, v); chk("R11", "ctrl untouched", v, 32'h0A);

      // mixed traffic against the model
      for (int i = 0; i < 400; i++) begin
         automatic bit [7:0] alist [12] = '{8'h00, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28,
                                            8'h2C, 8'h2C, 8'h28, 8'h3C, 8'h40, 8'h30};
         bus_addr       = alist[$urandom_range(0, 11)];
         bus_wr         = ($urandom_range(0, 2) == 0);
         bus_rd         = ($urandom_range(0, 1) == 0);
         bus_wdata      = $urandom;
         core_in_ready  = ($urandom_range(0, 3) == 0);
         core_out_valid = ($urandom_range(0, 3) == 0);
         core_out_block = {$urandom, $urandom};
         step();
      end
      bus_wr = 0; bus_rd = 0; core_in_ready = 0; core_out_valid = 0;
      step();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule